// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Status Word

This block is a combinational arithmetic and logic datapath for 8-bit and 16-bit operands, paired with a registered 16-bit status word. In one cycle it forms the sum or difference of two operands, an increment or decrement of the first operand, a bitwise AND, OR or XOR, or a plain copy of the second operand. It also computes the carry, half-carry, parity, zero, sign and signed-overflow conditions for the operand size that is selected.

The status word loads on a clock edge only when the write enable is high. Add-with-carry and subtract-with-borrow take the carry-in from the stored carry bit. Three control bits sit in the same word: single-step, interrupt-enable and direction. Arithmetic and logic writes never touch them. They are loaded only through a dedicated control load port, so an execution pipeline can run the unit every cycle and commit flags only for operations that retire.

Top module: `alu16_flags`

## Requirements
- R1: Opcodes on `op_i` (4 bits) are ADD=0, ADC=1, SUB=2, SBB=3. The result is a+b, a+b+CF, a−b and a−b−CF, reduced modulo the active size, where CF is the stored carry bit.
- R2: INC=4 gives a+1 and DEC=5 gives a−1. A flag write after either updates OF, SF, ZF, AF and PF and leaves CF unchanged.
- R3: AND=6, OR=7 and XOR=8 give the bitwise result. A flag write after them clears CF and OF, leaves AF unchanged, and updates SF, ZF and PF.
- R4: `word_i`=0 selects byte size. Only bits 7:0 of each operand are used, result bits 15:8 read 0, and all flags refer to the 8-bit result.
- R5: For arithmetic, CF is set on a carry out of the top bit of the active size during addition, and on a borrow during subtraction.
- R6: AF is set on a carry out of bit 3 during addition, or on a borrow into bit 3 during subtraction.
- R7: PF is 1 when result bits 7:0 hold an even number of ones and 0 otherwise, for both sizes.
- R8: ZF is set when the sized result is zero. SF copies bit 7 of the result (byte) or bit 15 (word).
- R9: OF is set when the signed result falls outside the two's-complement range of the active size.
- R10: The status word changes only on a rising clock edge with `flag_we_i`=1. PASS=9 and the unused codes 10..15 output the sized second operand and leave every flag unchanged.
- R11: With `ctl_we_i`=1, `ctl_i[0]`, `ctl_i[1]` and `ctl_i[2]` load status bits 8, 9 and 10 on the next edge. Flag writes never alter these three bits.
- R12: The status layout is CF=bit 0, PF=2, AF=4, ZF=6, SF=7, OF=11, with bits 1, 3, 5 and 12..15 reading 0. An active-low reset clears the entire word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opa_i | input | 16 | First operand |
| opb_i | input | 16 | Second operand |
| op_i | input | 4 | Operation code |
| word_i | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| flag_we_i | input | 1 | Commit the computed flags on this edge |
| ctl_we_i | input | 1 | Load the three control bits on this edge |
| ctl_i | input | 3 | Control bits: [0] single-step, [1] interrupt enable, [2] direction |
| res_o | output | 16 | Combinational result |
| flags_o | output | 16 | Registered status word |

## Verification
Word additions straddle the signed limit (0x7FFF+1) and the unsigned limit (0xFFFF+1), so overflow and carry are seen apart from each other. Byte operations put nonzero data in the upper operand halves to show that size selection, rather than the operand values, decides the carry, sign and zero bits. ADC and SBB run with the stored carry both set and clear, which separates the plain forms from the carry-using forms. INC and DEC run across wrap points with carry preset to each value, which shows that CF is preserved. Logic operations follow a half-carry that was set on purpose, so they confirm that AF is kept while CF and OF are cleared.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_PASS = 4'd9
  } alu_op_e;

  localparam int FB_CF = 0;
  localparam int FB_PF = 2;
  localparam int FB_AF = 4;
  localparam int FB_ZF = 6;
  localparam int FB_SF = 7;
  localparam int FB_TF = 8;
  localparam int FB_IF = 9;
  localparam int FB_DF = 10;
  localparam int FB_OF = 11;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } stat_t;
endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  input  logic          cin_i,   // carry-in, or borrow-in when sub_i
  input  logic          word_i,
  output logic [DW-1:0] sum_o,
  output logic          cf_o,
  output logic          af_o,
  output logic          of_o
);
  localparam int HW = DW / 2;

  logic [DW-1:0] b_eff;
  logic          c0;
  logic [DW:0]   full;
  logic [HW:0]   half;
  logic [4:0]    nib;
  logic          cout, sa, sb, ss;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    c0    = sub_i ? ~cin_i : cin_i;
    full  = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, c0};
    half  = {1'b0, a_i[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, c0};
    nib   = {1'b0, a_i[3:0]} + {1'b0, b_eff[3:0]} + {4'b0, c0};
    if (word_i) begin
      sum_o = full[DW-1:0];
      cout  = full[DW];
      sa    = a_i[DW-1];
      sb    = b_eff[DW-1];
      ss    = full[DW-1];
    end else begin
      sum_o = {{(DW-HW){1'b0}}, half[HW-1:0]};
      cout  = half[HW];
      sa    = a_i[HW-1];
      sb    = b_eff[HW-1];
      ss    = half[HW-1];
    end
    // subtraction: carry out of the inverted add means no borrow
    cf_o = cout ^ sub_i;
    af_o = nib[4] ^ sub_i;
    of_o = (sa == sb) && (ss != sa);
  end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     b_i,
  input  alu16_pkg::alu_op_e op_i,
  input  logic              word_i,
  output logic [DW-1:0]     res_o
);
  import alu16_pkg::*;
  localparam int HW = DW / 2;

  logic [DW-1:0] raw;
  logic [DW-1:0] size_mask;

  always_comb begin
    unique case (op_i)
      OP_AND:  raw = a_i & b_i;
      OP_OR:   raw = a_i | b_i;
      OP_XOR:  raw = a_i ^ b_i;
      default: raw = b_i;
    endcase
    size_mask = word_i ? {DW{1'b1}} : {{(DW-HW){1'b0}}, {HW{1'b1}}};
    res_o     = raw & size_mask;
  end
endmodule

// File: rtl/alu16_flag_reg.sv
module alu16_flag_reg (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  alu16_pkg::stat_t stat_i,
  input  logic             ctl_we_i,
  input  logic [2:0]       ctl_i,
  output alu16_pkg::stat_t stat_o,
  output logic [15:0]      flags_o
);
  import alu16_pkg::*;

  stat_t      stat_q;
  logic [2:0] ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      ctl_q  <= '0;
    end else begin
      if (we_i)     stat_q <= stat_i;
      if (ctl_we_i) ctl_q  <= ctl_i;
    end
  end

  always_comb begin
    flags_o        = '0;
    flags_o[FB_CF] = stat_q.cf;
    flags_o[FB_PF] = stat_q.pf;
    flags_o[FB_AF] = stat_q.af;
    flags_o[FB_ZF] = stat_q.zf;
    flags_o[FB_SF] = stat_q.sf;
    flags_o[FB_TF] = ctl_q[0];
    flags_o[FB_IF] = ctl_q[1];
    flags_o[FB_DF] = ctl_q[2];
    flags_o[FB_OF] = stat_q.of;
  end

  assign stat_o = stat_q;

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !ctl_we_i) |=> $stable(flags_o));

  assert_ctl_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> (flags_o[FB_DF:FB_TF] == $past(ctl_i)));

  assert_ctl_keep_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !ctl_we_i) |=> $stable(flags_o[FB_DF:FB_TF]));
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic [3:0]    op_i,
  input  logic          word_i,
  input  logic          flag_we_i,
  input  logic          ctl_we_i,
  input  logic [2:0]    ctl_i,
  output logic [DW-1:0] res_o,
  output logic [15:0]   flags_o
);
  import alu16_pkg::*;
  localparam int HW = DW / 2;

  alu_op_e       op;
  stat_t         stat_q, stat_n;
  logic          is_arith, is_logic, keep_cf;
  logic          sub, cin;
  logic [DW-1:0] b_arith, sum, lres;
  logic          a_cf, a_af, a_of;

  always_comb begin
    op       = alu_op_e'(op_i);
    is_arith = 1'b1;
    is_logic = 1'b0;
    keep_cf  = 1'b0;
    sub      = 1'b0;
    cin      = 1'b0;
    b_arith  = opb_i;
    unique case (op)
      OP_ADD: ;
      OP_ADC: cin = stat_q.cf;
      OP_SUB: sub = 1'b1;
      OP_SBB: begin sub = 1'b1; cin = stat_q.cf; end
      OP_INC: begin b_arith = '0; cin = 1'b1; keep_cf = 1'b1; end
      OP_DEC: begin b_arith = {{(DW-1){1'b0}}, 1'b1}; sub = 1'b1; keep_cf = 1'b1; end
      OP_AND, OP_OR, OP_XOR: begin is_arith = 1'b0; is_logic = 1'b1; end
      default: is_arith = 1'b0;
    endcase
  end

  alu16_addsub #(.DW(DW)) u_addsub (
    .a_i    (opa_i),
    .b_i    (b_arith),
    .sub_i  (sub),
    .cin_i  (cin),
    .word_i (word_i),
    .sum_o  (sum),
    .cf_o   (a_cf),
    .af_o   (a_af),
    .of_o   (a_of)
  );

  alu16_logic #(.DW(DW)) u_logic (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .op_i   (op),
    .word_i (word_i),
    .res_o  (lres)
  );

  always_comb begin
    res_o  = is_arith ? sum : lres;
    stat_n = stat_q;
    if (is_arith) begin
      if (!keep_cf) stat_n.cf = a_cf;
      stat_n.af = a_af;
      stat_n.of = a_of;
    end else if (is_logic) begin
      stat_n.cf = 1'b0;
      stat_n.of = 1'b0;
    end
    if (is_arith || is_logic) begin
      stat_n.zf = (res_o == '0);
      stat_n.sf = word_i ? res_o[DW-1] : res_o[HW-1];
      stat_n.pf = ~^res_o[7:0];
    end
  end

  alu16_flag_reg u_flag_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (flag_we_i),
    .stat_i   (stat_n),
    .ctl_we_i (ctl_we_i),
    .ctl_i    (ctl_i),
    .stat_o   (stat_q),
    .flags_o  (flags_o)
  );

  assert_incdec_keep_cf_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && (op_i == 4'd4 || op_i == 4'd5)) |=> (flags_o[FB_CF] == $past(flags_o[FB_CF])));

  assert_logic_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i >= 4'd6 && op_i <= 4'd8) |=> (!flags_o[FB_CF] && !flags_o[FB_OF]));

  assert_logic_keep_af_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i >= 4'd6 && op_i <= 4'd8) |=> $stable(flags_o[FB_AF]));

  assert_byte_upper_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_i |-> (res_o[DW-1:HW] == '0));

  assert_zero_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i <= 4'd8) |=> (flags_o[FB_ZF] == ($past(res_o) == '0)));

  assert_pass_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 4'd9 && !ctl_we_i) |=> $stable(flags_o));
endmodule

// File: tb/alu16_flags_bench.sv
module alu16_flags_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] opa_i = '0, opb_i = '0;
  logic [3:0]  op_i = '0;
  logic        word_i = 1'b1, flag_we_i = 1'b0, ctl_we_i = 1'b0;
  logic [2:0]  ctl_i = '0;
  logic [15:0] res_o, flags_o;

  int n_chk = 0, n_fail = 0;
  logic [15:0] fl_exp = '0;

  always #2 clk_i = ~clk_i;

  alu16_flags u_alu16_flags (
    .clk_i, .rst_ni, .opa_i, .opb_i, .op_i, .word_i,
    .flag_we_i, .ctl_we_i, .ctl_i, .res_o, .flags_o
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic w, input logic [15:0] f,
                       output logic [15:0] r, output logic [15:0] nf);
    int wd, mask, hlf, ua, ub, sa, sb, u, s, nn, c;
    logic arith, lg;
    wd = w ? 16 : 8;
    mask = (1 << wd) - 1;
    hlf = 1 << (wd - 1);
    ua = int'(a) & mask;
    ub = int'(b) & mask;
    sa = (ua >= hlf) ? ua - 2 * hlf : ua;
    sb = (ub >= hlf) ? ub - 2 * hlf : ub;
    c = int'(f[0]);
    nf = f; arith = 1'b1; lg = 1'b0;
    u = 0; s = 0; nn = 0; r = '0;
    case (op)
      4'd0: begin u = ua + ub;     s = sa + sb;     nn = (ua & 15) + (ub & 15);     end
      4'd1: begin u = ua + ub + c; s = sa + sb + c; nn = (ua & 15) + (ub & 15) + c; end
      4'd2: begin u = ua - ub;     s = sa - sb;     nn = (ua & 15) - (ub & 15);     end
      4'd3: begin u = ua - ub - c; s = sa - sb - c; nn = (ua & 15) - (ub & 15) - c; end
      4'd4: begin u = ua + 1;      s = sa + 1;      nn = (ua & 15) + 1;             end
      4'd5: begin u = ua - 1;      s = sa - 1;      nn = (ua & 15) - 1;             end
      4'd6: begin arith = 1'b0; lg = 1'b1; r = 16'(ua & ub); end
      4'd7: begin arith = 1'b0; lg = 1'b1; r = 16'(ua | ub); end
      4'd8: begin arith = 1'b0; lg = 1'b1; r = 16'(ua ^ ub); end
      default: begin arith = 1'b0; r = 16'(ub); end
    endcase
    if (arith) begin
      r = 16'(u & mask);
      if (op != 4'd4 && op != 4'd5) nf[0] = (u < 0) || (u > mask);
      nf[11] = (s < -hlf) || (s > hlf - 1);
      nf[4] = (nn < 0) || (nn > 15);
    end
    if (lg) begin nf[0] = 1'b0; nf[11] = 1'b0; end
    if (arith || lg) begin
      nf[6] = (r == 16'd0);
      nf[7] = r[wd-1];
      nf[2] = ~^r[7:0];
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic w, input logic we, input string tag);
    logic [15:0] er, ef;
    @(negedge clk_i);
    op_i = op; opa_i = a; opb_i = b; word_i = w; flag_we_i = we; ctl_we_i = 1'b0;
    #1;
    model(op, a, b, w, fl_exp, er, ef);
    chk({tag, " result"}, res_o, er);
    @(posedge clk_i); #1;
    if (we) fl_exp = ef;
    chk({tag, " flags"}, flags_o, fl_exp);
  endtask

  task automatic t_reset;
    #1 chk("R12 reset word", flags_o, 16'h0000);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    #1 chk("R12 after release", flags_o, 16'h0000);
  endtask

  task automatic t_add_sub;
    apply(4'd0, 16'h7FFF, 16'h0001, 1'b1, 1'b1, "R9 R6 add signed limit");
    apply(4'd0, 16'hFFFF, 16'h0001, 1'b1, 1'b1, "R5 R8 add unsigned wrap");
    apply(4'd2, 16'h0000, 16'h0001, 1'b1, 1'b1, "R5 R6 sub borrow");
    apply(4'd2, 16'h8000, 16'h0001, 1'b1, 1'b1, "R9 sub signed limit");
    apply(4'd0, 16'h1234, 16'h0F0F, 1'b1, 1'b1, "R1 R7 add plain");
  endtask

  task automatic t_carry_ops;
    apply(4'd0, 16'hFFFF, 16'h0001, 1'b1, 1'b1, "R5 set cf");
    apply(4'd1, 16'h0001, 16'h0001, 1'b1, 1'b1, "R1 adc cf1");
    apply(4'd1, 16'h0001, 16'h0001, 1'b1, 1'b1, "R1 adc cf0");
    apply(4'd2, 16'h0000, 16'h0001, 1'b1, 1'b1, "R5 set borrow");
    apply(4'd3, 16'h0010, 16'h0001, 1'b1, 1'b1, "R1 R6 sbb cf1");
    apply(4'd3, 16'h0010, 16'h0010, 1'b1, 1'b1, "R1 sbb cf0");
  endtask

  task automatic t_inc_dec;
    apply(4'd0, 16'hFFFF, 16'h0001, 1'b1, 1'b1, "R2 preset cf1");
    apply(4'd4, 16'h7FFF, 16'h0000, 1'b1, 1'b1, "R2 inc keeps cf1");
    apply(4'd0, 16'h0001, 16'h0001, 1'b1, 1'b1, "R2 preset cf0");
    apply(4'd4, 16'hFFFF, 16'h0000, 1'b1, 1'b1, "R2 inc wrap keeps cf0");
    apply(4'd5, 16'h0000, 16'h0000, 1'b0, 1'b1, "R2 dec byte wrap");
    apply(4'd5, 16'h8000, 16'h0000, 1'b1, 1'b1, "R2 R9 dec signed limit");
  endtask

  task automatic t_logic;
    apply(4'd0, 16'h000F, 16'h0001, 1'b1, 1'b1, "R6 preset af");
    apply(4'd6, 16'hF0F0, 16'h0FF0, 1'b1, 1'b1, "R3 and");
    apply(4'd7, 16'h8000, 16'h0003, 1'b1, 1'b1, "R3 R8 or sign");
    apply(4'd8, 16'h5A5A, 16'h5A5A, 1'b1, 1'b1, "R3 R8 xor zero");
    apply(4'd8, 16'h0000, 16'h0007, 1'b0, 1'b1, "R3 R7 xor odd parity");
  endtask

  task automatic t_byte;
    apply(4'd0, 16'h12FF, 16'h3401, 1'b0, 1'b1, "R4 byte add wrap");
    apply(4'd0, 16'hAA7F, 16'h5501, 1'b0, 1'b1, "R4 R9 byte overflow");
    apply(4'd2, 16'h0100, 16'h0001, 1'b0, 1'b1, "R4 R5 byte borrow");
    apply(4'd7, 16'hFF80, 16'hFF00, 1'b0, 1'b1, "R4 R8 byte sign");
  endtask

  task automatic t_we_hold;
    apply(4'd0, 16'hFFFF, 16'h0001, 1'b1, 1'b0, "R10 no write");
    apply(4'd9, 16'h0000, 16'hBEEF, 1'b1, 1'b1, "R10 pass word");
    apply(4'd9, 16'h0000, 16'hBEEF, 1'b0, 1'b1, "R10 pass byte");
    apply(4'd15, 16'h0000, 16'h0000, 1'b1, 1'b1, "R10 unused code");
  endtask

  task automatic t_ctl;
    @(negedge clk_i);
    flag_we_i = 1'b0; ctl_we_i = 1'b1; ctl_i = 3'b101;
    @(posedge clk_i); #1;
    fl_exp[10:8] = 3'b101;
    chk("R11 ctl load", flags_o, fl_exp);
    apply(4'd2, 16'h0000, 16'h0001, 1'b1, 1'b1, "R11 flag write keeps ctl");
    @(negedge clk_i);
    ctl_we_i = 1'b1; ctl_i = 3'b010;
    @(posedge clk_i); #1;
    fl_exp[10:8] = 3'b010;
    chk("R11 ctl reload", flags_o, fl_exp);
    @(negedge clk_i);
    ctl_we_i = 1'b0; rst_ni = 1'b0;
    #1 fl_exp = '0;
    chk("R12 reset clears", flags_o, 16'h0000);
    @(negedge clk_i) rst_ni = 1'b1;
  endtask

  initial begin
    t_reset();
    t_add_sub();
    t_carry_ops();
    t_inc_dec();
    t_logic();
    t_byte();
    t_we_hold();
    t_ctl();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule